// File: doc/BRIEF.md
# Multiplexed Code-Wheel Readout Scanner

This block polls a multi-turn gear assembly whose seven code wheels share one 3-bit data bus. It drives a 3-bit select bus, holds each select value for a fixed number of clock cycles so that the slow optical outputs can settle, and samples the bus at the end of that interval. The incoming data passes through a two-flop synchroniser before it is sampled, because the assembly runs without any relation to the system clock.

Select value 0 does not address a wheel. It returns a configuration word. Bit 2 of that word is a fixed marker that must read 1, and bit 0 reports whether the assembly counts 12 or 14 bits of turns. Select values 1 to 7 return the 3-bit code of the wheel with that number. The scanner cycles through all eight select values without stopping. After each complete pass it updates a 21-bit parallel word and the resolution flag together, and it pulses a strobe. Gray-code reconstruction from the wheel codes is done downstream.

Top module: `mtw_scan`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, sel_o, frame_o, res14_o, frame_valid_o and cfg_err_o are all zero.
- R2: sel_o steps through 0, 1, 2, …, 7 and then wraps to 0. Each change increments it by exactly one, modulo 8.
- R3: Every select value is held for exactly SETTLE_CYC clock cycles. The default of 3200 cycles gives 64 µs at a 50 MHz clock.
- R4: Wheel k (select value k, 1 ≤ k ≤ 7) is placed in frame_o[3k-1:3k-3], so wheel 1 occupies bits 2:0 and wheel 7 occupies bits 20:18. frame_o changes only in a cycle where frame_valid_o is high.
- R5: res14_o takes bit 0 of the configuration word read at select value 0 in the same sweep (1 means 14-bit, 0 means 12-bit). It updates together with frame_o.
- R6: frame_valid_o is a one-cycle pulse. It rises once per good sweep, SETTLE_CYC×8 cycles apart, and sel_o is 0 while it is high.
- R7: Only the synchronised bus value present at the end of a select slot is captured. A value that differs from the final one during the first three cycles of a slot has no effect on frame_o.
- R8: If bit 2 of the configuration word reads 0, no frame_valid_o pulse occurs for that sweep, and frame_o and res14_o keep their previous values.
- R9: cfg_err_o is set by the first sweep whose configuration marker reads 0. It stays set until reset, even after later good sweeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_dat | input | 3 | Shared data bus from the gear assembly (asynchronous) |
| sel_o | output | 3 | Select bus: 0 selects the configuration word, 1 to 7 select a wheel |
| frame_o | output | 21 | Captured wheel codes, 3 bits per wheel |
| res14_o | output | 1 | Resolution flag from the configuration word |
| frame_valid_o | output | 1 | One-cycle strobe after each good sweep |
| cfg_err_o | output | 1 | Sticky flag: the configuration marker was seen as 0 |

## Verification
Committing the sweep and judging the configuration marker both happen at the same clock edge, the one that closes the wheel-7 slot. The marker is read early in the sweep but only acted on at that commit. The bench provokes the collision by clearing the marker bit in the emulated assembly while new wheel codes are presented. It then expects no strobe in that sweep, an unchanged frame and resolution flag, and cfg_err_o set. Strobes must return on the next good sweep while cfg_err_o stays set.

// File: rtl/mtw_pkg.sv
package mtw_pkg;
   localparam int unsigned MTW_DAT_W    = 3;
   localparam int unsigned MTW_SEL_W    = 3;
   localparam int unsigned MTW_MARK_BIT = 2;
   localparam int unsigned MTW_RES_BIT  = 0;
   typedef logic [MTW_DAT_W-1:0] mtw_code_t;
endpackage

// File: rtl/mtw_sync.sv
module mtw_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("mtw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mtw_settle.sv
module mtw_settle #(
   parameter int unsigned SETTLE_CYC = 3200
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);
endmodule

// File: rtl/mtw_capture.sv
module mtw_capture
   import mtw_pkg::*;
#(
   parameter int unsigned WHEELS = 7,
   parameter int unsigned SEL_W  = MTW_SEL_W,
   parameter int unsigned DAT_W  = MTW_DAT_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic [SEL_W-1:0]        sel,
   input  logic [DAT_W-1:0]        dat,
   output logic [WHEELS*DAT_W-1:0] frame,
   output logic                    res14,
   output logic                    valid,
   output logic                    err
);
   localparam int unsigned FW = WHEELS * DAT_W;
   localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(WHEELS);

   logic [FW-1:0] shadow_q, shadow_nx;
   logic          mark_q, res_q;
   logic          cfg_slot, last_slot;

   assign cfg_slot  = tick && (sel == '0);
   assign last_slot = tick && (sel == LAST_SEL);

   always_comb begin
      shadow_nx = shadow_q;
      for (int k = 1; k <= int'(WHEELS); k++) begin
         if (tick && (sel == SEL_W'(k)))
            shadow_nx[(k-1)*DAT_W +: DAT_W] = dat;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         mark_q   <= 1'b0;
         res_q    <= 1'b0;
         frame    <= '0;
         res14    <= 1'b0;
         valid    <= 1'b0;
         err      <= 1'b0;
      end else begin
         shadow_q <= shadow_nx;
         valid    <= 1'b0;
         if (cfg_slot) begin
            mark_q <= dat[MTW_MARK_BIT];
            res_q  <= dat[MTW_RES_BIT];
         end
         if (last_slot) begin
            if (mark_q) begin
               frame <= shadow_nx;
               res14 <= res_q;
               valid <= 1'b1;
            end else begin
               err <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/mtw_scan.sv
module mtw_scan
   import mtw_pkg::*;
#(
   parameter int unsigned SETTLE_CYC  = 3200,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned WHEELS      = 7
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [MTW_DAT_W-1:0]          rd_dat,
   output logic [MTW_SEL_W-1:0]          sel_o,
   output logic [WHEELS*MTW_DAT_W-1:0]   frame_o,
   output logic                          res14_o,
   output logic                          frame_valid_o,
   output logic                          cfg_err_o
);
   generate
      if (WHEELS != (2**MTW_SEL_W) - 1) begin : g_bad_wheels
         $error("mtw_scan: WHEELS must fill the select space minus slot 0");
      end
      if (SETTLE_CYC < SYNC_STAGES + 2) begin : g_bad_settle
         $error("mtw_scan: SETTLE_CYC too short for the synchroniser");
      end
   endgenerate

   logic [MTW_DAT_W-1:0] dat_s;
   logic                 tick;

   mtw_sync #(.W(MTW_DAT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rd_dat), .q(dat_s)
   );

   mtw_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) sel_o <= '0;
      else if (tick) sel_o <= sel_o + 1'b1;
   end

   mtw_capture #(.WHEELS(WHEELS), .SEL_W(MTW_SEL_W), .DAT_W(MTW_DAT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel_o), .dat(dat_s),
      .frame(frame_o), .res14(res14_o), .valid(frame_valid_o), .err(cfg_err_o)
   );
endmodule

// File: rtl/mtw_scan_chk.sv
module mtw_scan_chk #(
   parameter int unsigned FW = 21
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    sel_o,
   input logic [FW-1:0] frame_o,
   input logic          res14_o,
   input logic          frame_valid_o,
   input logic          cfg_err_o
);
   assert_sel_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o != $past(sel_o)) |-> (sel_o == $past(sel_o) + 3'd1));

   assert_frame_only_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_o != $past(frame_o)) |-> frame_valid_o);

   assert_res_only_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (res14_o != $past(res14_o)) |-> frame_valid_o);

   assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid_o |=> !frame_valid_o);

   assert_strobe_at_slot0_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid_o |-> (sel_o == 3'd0));

   assert_no_strobe_on_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_err_o) |-> !frame_valid_o);

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |=> cfg_err_o);
endmodule

bind mtw_scan mtw_scan_chk #(.FW(WHEELS*3)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel_o(sel_o), .frame_o(frame_o),
   .res14_o(res14_o), .frame_valid_o(frame_valid_o), .cfg_err_o(cfg_err_o)
);

// File: tb/mtw_scan_bench.sv
module mtw_scan_bench;
   localparam int unsigned SET = 8;
   localparam int unsigned SWEEP = SET * 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  rd_dat;
   logic [2:0]  sel_o;
   logic [20:0] frame_o;
   logic        res14_o, frame_valid_o, cfg_err_o;

   logic [2:0] whl [1:7];
   logic [2:0] cfg_word = 3'b100;
   logic       spoil = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   always_comb begin
      if (sel_o == 3'd0) rd_dat = cfg_word;
      else if (spoil)    rd_dat = ~whl[sel_o];
      else               rd_dat = whl[sel_o];
   end

   mtw_scan #(.SETTLE_CYC(SET)) u_mtw_scan (
      .clk(clk), .rst_n(rst_n), .rd_dat(rd_dat), .sel_o(sel_o),
      .frame_o(frame_o), .res14_o(res14_o), .frame_valid_o(frame_valid_o),
      .cfg_err_o(cfg_err_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [20:0] pack();
      logic [20:0] f;
      for (int k = 1; k <= 7; k++) f[3*(k-1) +: 3] = whl[k];
      return f;
   endfunction

   task automatic wait_strobe(output bit seen, output int waited);
      seen = 1'b0;
      waited = 0;
      for (int i = 0; i < 3*SWEEP; i++) begin
         @(negedge clk);
         waited++;
         if (frame_valid_o) begin seen = 1'b1; break; end
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(sel_o == 0 && frame_o == 0 && !res14_o && !frame_valid_o && !cfg_err_o,
          "R1", "outputs in reset", {sel_o, frame_o[19:0]}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sel_o == 0 && frame_o == 0 && !frame_valid_o && !cfg_err_o,
          "R1", "outputs after release", {sel_o, frame_o[19:0]}, 0);
   endtask

   task automatic t_sequence();
      logic [2:0] prev = sel_o;
      int run = 0;
      bit first = 1'b1;
      for (int i = 0; i < 2*SWEEP; i++) begin
         @(negedge clk);
         run++;
         if (sel_o != prev) begin
            chk(sel_o == prev + 3'd1, "R2", "select step", sel_o, prev + 3'd1);
            if (!first) chk(run == SET, "R3", "slot length", run, SET);
            first = 1'b0;
            run = 0;
            prev = sel_o;
         end
      end
   endtask

   task automatic t_frame(input logic [20:0] pat, input bit r14);
      bit seen;
      int w;
      wait_strobe(seen, w);
      for (int k = 1; k <= 7; k++) whl[k] = pat[3*(k-1) +: 3];
      cfg_word = {1'b1, 1'b0, r14};
      wait_strobe(seen, w);
      chk(seen, "R6", "strobe present", seen, 1);
      chk(frame_o == pack(), "R4", "frame layout", frame_o, pack());
      chk(res14_o == r14, "R5", "resolution flag", res14_o, r14);
      @(negedge clk);
      chk(!frame_valid_o, "R6", "strobe one cycle", frame_valid_o, 0);
   endtask

   task automatic t_period();
      bit seen;
      int w;
      wait_strobe(seen, w);
      wait_strobe(seen, w);
      chk(seen && w == SWEEP, "R6", "strobe period", w, SWEEP);
   endtask

   task automatic t_glitch();
      bit seen;
      int w;
      wait_strobe(seen, w);
      for (int k = 1; k <= 7; k++) whl[k] = 3'(k ^ 5);
      while (sel_o != 3'd3) @(negedge clk);
      spoil = 1'b1;
      repeat (3) @(negedge clk);
      spoil = 1'b0;
      wait_strobe(seen, w);
      chk(frame_o == pack(), "R7", "early slot value ignored", frame_o, pack());
   endtask

   task automatic t_cfg_error();
      bit seen;
      int w;
      logic [20:0] held;
      logic        hres;
      wait_strobe(seen, w);
      held = frame_o;
      hres = res14_o;
      for (int k = 1; k <= 7; k++) whl[k] = 3'(7 - k);
      cfg_word = {1'b0, 1'b0, ~hres};
      w = 0;
      seen = 1'b0;
      while (w < SWEEP + 4) begin
         @(negedge clk);
         w++;
         if (frame_valid_o) seen = 1'b1;
      end
      chk(!seen, "R8", "strobe suppressed", seen, 0);
      chk(frame_o == held, "R8", "frame held", frame_o, held);
      chk(res14_o == hres, "R8", "resolution held", res14_o, hres);
      chk(cfg_err_o, "R9", "error set", cfg_err_o, 1);
      cfg_word = {1'b1, 1'b0, hres};
      wait_strobe(seen, w);
      wait_strobe(seen, w);
      chk(seen, "R8", "strobe resumes", seen, 1);
      chk(frame_o == pack(), "R4", "frame after recovery", frame_o, pack());
      chk(cfg_err_o, "R9", "error sticky", cfg_err_o, 1);
   endtask

   initial begin
      for (int k = 1; k <= 7; k++) whl[k] = 3'(k);
      repeat (3) @(negedge clk);
      t_reset();
      t_sequence();
      t_frame(21'h1A2B3C, 1'b1);
      t_frame(21'h0F0F0F, 1'b0);
      t_frame(21'h1FFFFF, 1'b1);
      t_period();
      t_glitch();
      t_cfg_error();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule